// File: doc/BRIEF.md
# Flash Mailbox Command Engine

A device-side mailbox that gives a host access to a word-addressed non-volatile store through a narrow register window. The window has sixteen 32-bit data registers, a command register and a status register, all reached over a plain single-cycle register bus. The host fills the data registers if needed, then writes a command word with its request bit set. The engine decodes the opcode, waits a configurable busy latency, moves words between the data window and an internal flash model, posts a result code, and clears the request bit. The host learns of completion by polling the command register until the request bit reads as 0.

Besides block reads and block writes, the engine takes a signed-header write, an update-authenticate command that succeeds only once a header has been delivered, and a power-cycle command that discards any pending header. Ranges that run off the end of the flash model are refused with an access error, and nothing is moved.

Top module: `nvm_mailbox`

## Requirements
- R1: After reset the data registers (bus offsets 1 to 16), the command register (offset 17) and the status register (offset 18) read 0; any other offset always reads 0.
- R2: A block write (opcode 0 in command bits 31:28) copies count+1 words (count in bits 27:24) from data offsets 1 upward into flash starting at the dword address in bits 23:2.
- R3: A block read (opcode 2) copies n words from flash at the dword address into data offsets 1 upward, where n is the count field and a count of 0 means sixteen words.
- R4: On completion the status register holds bit 29 set, the finished opcode in bits 7:4 and a result code in bits 3:0 (0 success, 1 authentication error, 2 access error, 3 unknown opcode), all other bits 0.
- R5: Writing the command register with bit 0 set starts a command; bit 0 then reads 1 for at least BUSY_CYCLES consecutive cycles and afterwards reads 0 with the rest of the command word unchanged. A command word with bit 0 clear is stored but starts nothing.
- R6: While a command is in progress, bus writes to the command register and to the data registers are ignored; bus writes to the status register are always ignored.
- R7: A block read or block write whose address plus word count exceeds FLASH_WORDS finishes with result 2 and changes neither flash nor data registers; a range ending exactly at FLASH_WORDS is accepted.
- R8: A block write with the header flag (bit 1) set, or addressed to dword 0x3fffff, is a header write: it leaves flash untouched and succeeds only when the address is 0x3fffff, otherwise it finishes with result 2.
- R9: Update-authenticate (opcode 1) finishes with result 0 if a successful header write has completed since the last update-authenticate or power cycle, otherwise with result 1; either way the pending header is consumed.
- R10: Power cycle (opcode 4) finishes with result 0 and discards any pending header.
- R11: Any other opcode finishes with result 3 and moves no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
A decode slip in the engine shows up at the status register within one cycle of the request bit clearing: a wrong opcode echo or result code is visible to the very next poll. A wrong transfer index or address offset surfaces only when the host reads the data window or reads the same flash range back, so each write scenario is followed by a read of the same range with known, distinct word values. A stale header-pending flag is invisible until the next update-authenticate, which is why header, power-cycle and authenticate commands are issued in sequences whose second result depends on the first.

// File: rtl/nvm_mbx_pkg.sv
package nvm_mbx_pkg;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_AUTH  = 4'h1;
  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_PWR   = 4'h4;

  localparam logic [3:0] RC_OK     = 4'h0;
  localparam logic [3:0] RC_AUTH   = 4'h1;
  localparam logic [3:0] RC_ACCESS = 4'h2;
  localparam logic [3:0] RC_BADOP  = 4'h3;

  localparam logic [21:0] HDR_ADDR = 22'h3fffff;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  cnt;
    logic [21:0] addr;
    logic        hdr;
    logic        req;
  } mbx_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_DONE
  } mbx_state_e;

endpackage

// File: rtl/nvm_mbx_store.sv
module nvm_mbx_store #(
  parameter int unsigned FLASH_WORDS = 64,
  localparam int unsigned FAW = $clog2(FLASH_WORDS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [FAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  logic [31:0] mem [FLASH_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/nvm_mbx_window.sv
module nvm_mbx_window #(
  parameter int unsigned DATA_WORDS = 16,
  localparam int unsigned IW = $clog2(DATA_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [31:0]   host_wdata,
  input  logic          busy,
  input  logic          eng_we,
  input  logic [IW-1:0] eng_idx,
  input  logic [31:0]   eng_wdata,
  output logic [31:0]   eng_rdata,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);

  logic [DATA_WORDS-1:0][31:0] regs_q, regs_d;
  logic [DATA_WORDS-1:0]       eng_sel, host_sel;

  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_sel
    assign eng_sel[g]  = eng_we && (eng_idx == IW'(g));
    assign host_sel[g] = host_we && !busy && (host_idx == IW'(g));
  end

  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < DATA_WORDS; i++) begin
      if (eng_sel[i])       regs_d[i] = eng_wdata;
      else if (host_sel[i]) regs_d[i] = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_data   = regs_q[rd_idx];
  assign eng_rdata = regs_q[eng_idx];

  // R6: host cannot disturb the window while a command runs
  a_r6_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_we) |=> $stable(regs_q));

  // R3: a word delivered by the engine lands at its index
  a_r3_engine_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> (regs_q[$past(eng_idx)] == $past(eng_wdata)));

endmodule

// File: rtl/nvm_mbx_engine.sv
module nvm_mbx_engine
  import nvm_mbx_pkg::*;
#(
  parameter int unsigned DATA_WORDS  = 16,
  parameter int unsigned FLASH_WORDS = 64,
  parameter int unsigned BUSY_CYCLES = 6,
  localparam int unsigned IW  = $clog2(DATA_WORDS),
  localparam int unsigned NW  = IW + 1,
  localparam int unsigned FAW = $clog2(FLASH_WORDS),
  localparam int unsigned CW  = $clog2(BUSY_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic [31:0]    cmd_wdata,
  output logic [31:0]    cmd_q,
  output logic [31:0]    stat_q,
  output logic           busy,
  output logic           win_we,
  output logic [IW-1:0]  win_idx,
  output logic           st_we,
  output logic [FAW-1:0] st_addr
);

  mbx_state_e    state_q, state_d;
  mbx_cmd_t      cmd_r, cmd_d;
  logic [CW-1:0] wait_q, wait_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   stat_d, stat_new;
  logic          hdr_q, hdr_d;

  logic [NW-1:0] n_rd, n_wr, nwords;
  logic [22:0]   end_addr;
  logic          oob, is_hdr, hdr_ok, xfer_go, last_idx;
  logic [3:0]    code;

  // Decode of the held command word
  assign n_rd     = (cmd_r.cnt == 4'd0) ? NW'(DATA_WORDS) : NW'(cmd_r.cnt);
  assign n_wr     = NW'(cmd_r.cnt) + NW'(1);
  assign nwords   = (cmd_r.op == OP_READ) ? n_rd : n_wr;
  assign end_addr = {1'b0, cmd_r.addr} + 23'(nwords);
  assign oob      = end_addr > 23'(FLASH_WORDS);
  assign is_hdr   = (cmd_r.op == OP_WRITE) && (cmd_r.hdr || (cmd_r.addr == HDR_ADDR));
  assign hdr_ok   = is_hdr && (cmd_r.addr == HDR_ADDR);
  assign xfer_go  = ((cmd_r.op == OP_READ) || ((cmd_r.op == OP_WRITE) && !is_hdr)) && !oob;
  assign last_idx = ({1'b0, idx_q} == (nwords - NW'(1)));

  always_comb begin
    case (cmd_r.op)
      OP_WRITE: code = is_hdr ? (hdr_ok ? RC_OK : RC_ACCESS) : (oob ? RC_ACCESS : RC_OK);
      OP_READ:  code = oob ? RC_ACCESS : RC_OK;
      OP_AUTH:  code = hdr_q ? RC_OK : RC_AUTH;
      OP_PWR:   code = RC_OK;
      default:  code = RC_BADOP;
    endcase
    stat_new       = '0;
    stat_new[29]   = 1'b1;
    stat_new[7:4]  = cmd_r.op;
    stat_new[3:0]  = code;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_r;
    wait_d  = wait_q;
    idx_d   = idx_q;
    stat_d  = stat_q;
    hdr_d   = hdr_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_we) begin
          cmd_d = mbx_cmd_t'(cmd_wdata);
          if (cmd_wdata[0]) begin
            state_d = ST_WAIT;
            wait_d  = '0;
          end
        end
      end
      ST_WAIT: begin
        if (wait_q == CW'(BUSY_CYCLES - 1)) begin
          idx_d   = '0;
          state_d = xfer_go ? ST_XFER : ST_DONE;
        end else begin
          wait_d = wait_q + CW'(1);
        end
      end
      ST_XFER: begin
        if (last_idx) state_d = ST_DONE;
        else          idx_d   = idx_q + IW'(1);
      end
      ST_DONE: begin
        cmd_d.req = 1'b0;
        stat_d    = stat_new;
        if ((cmd_r.op == OP_AUTH) || (cmd_r.op == OP_PWR)) hdr_d = 1'b0;
        else if (hdr_ok)                                  hdr_d = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_r   <= '0;
      wait_q  <= '0;
      idx_q   <= '0;
      stat_q  <= '0;
      hdr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_r   <= cmd_d;
      wait_q  <= wait_d;
      idx_q   <= idx_d;
      stat_q  <= stat_d;
      hdr_q   <= hdr_d;
    end
  end

  assign cmd_q   = cmd_r;
  assign busy    = (state_q != ST_IDLE);
  assign win_we  = (state_q == ST_XFER) && (cmd_r.op == OP_READ);
  assign st_we   = (state_q == ST_XFER) && (cmd_r.op == OP_WRITE);
  assign win_idx = idx_q;
  assign st_addr = cmd_r.addr[FAW-1:0] + FAW'(idx_q);

  // Length of the current busy period, for the latency check only
  logic [15:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         busy_len <= '0;
    else if ((state_q == ST_IDLE) && cmd_we && cmd_wdata[0]) busy_len <= 16'd1;
    else if (busy && (busy_len != 16'hffff))            busy_len <= busy_len + 16'd1;
  end

  // R5: request bit is set whenever the engine is not idle
  a_r5_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> cmd_q[0]);

  // R5: request bit holds for at least the busy latency
  a_r5_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0]) |-> (busy_len >= 16'(BUSY_CYCLES)));

  // R6: held command word does not move mid-command
  a_r6_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) || (state_q == ST_XFER)) |=> $stable(cmd_q));

  // R4: completion posts a valid status echoing the opcode and drops the request
  a_r4_done_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (stat_q[29] && (stat_q[7:4] == $past(cmd_q[31:28])) && !cmd_q[0]));

  // R7: an out-of-range transfer reports an access error
  a_r7_oob_access: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DONE) && oob && ((cmd_r.op == OP_READ) || ((cmd_r.op == OP_WRITE) && !is_hdr)))
      |=> (stat_q[3:0] == RC_ACCESS));

  // R7: flash is never written outside its range
  a_r7_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (({1'b0, cmd_r.addr} + 23'(idx_q)) < 23'(FLASH_WORDS)));

endmodule

// File: rtl/nvm_mailbox.sv
module nvm_mailbox #(
  parameter int unsigned DATA_WORDS  = 16,
  parameter int unsigned FLASH_WORDS = 64,
  parameter int unsigned BUSY_CYCLES = 6,
  parameter int unsigned BUS_AW      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned IW       = $clog2(DATA_WORDS);
  localparam int unsigned FAW      = $clog2(FLASH_WORDS);
  localparam int unsigned OFS_CMD  = DATA_WORDS + 1;
  localparam int unsigned OFS_STAT = DATA_WORDS + 2;

  logic           hit_data, hit_cmd, hit_stat;
  logic [IW-1:0]  host_idx;
  logic [31:0]    cmd_q, stat_q, win_rd, win_eng_rd, st_rdata;
  logic           busy, win_we, st_we;
  logic [IW-1:0]  win_idx;
  logic [FAW-1:0] st_addr;

  assign hit_data = (bus_addr != '0) && (bus_addr <= BUS_AW'(DATA_WORDS));
  assign hit_cmd  = (bus_addr == BUS_AW'(OFS_CMD));
  assign hit_stat = (bus_addr == BUS_AW'(OFS_STAT));
  assign host_idx = IW'(bus_addr - BUS_AW'(1));

  nvm_mbx_engine #(
    .DATA_WORDS (DATA_WORDS),
    .FLASH_WORDS(FLASH_WORDS),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (bus_we && hit_cmd),
    .cmd_wdata(bus_wdata),
    .cmd_q    (cmd_q),
    .stat_q   (stat_q),
    .busy     (busy),
    .win_we   (win_we),
    .win_idx  (win_idx),
    .st_we    (st_we),
    .st_addr  (st_addr)
  );

  nvm_mbx_window #(.DATA_WORDS(DATA_WORDS)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (bus_we && hit_data),
    .host_idx  (host_idx),
    .host_wdata(bus_wdata),
    .busy      (busy),
    .eng_we    (win_we),
    .eng_idx   (win_idx),
    .eng_wdata (st_rdata),
    .eng_rdata (win_eng_rd),
    .rd_idx    (host_idx),
    .rd_data   (win_rd)
  );

  nvm_mbx_store #(.FLASH_WORDS(FLASH_WORDS)) u_store (
    .clk  (clk),
    .we   (st_we),
    .addr (st_addr),
    .wdata(win_eng_rd),
    .rdata(st_rdata)
  );

  always_comb begin
    if (hit_data)      bus_rdata = win_rd;
    else if (hit_cmd)  bus_rdata = cmd_q;
    else if (hit_stat) bus_rdata = stat_q;
    else               bus_rdata = '0;
  end

endmodule

// File: tb/test_nvm_mailbox.sv
module test_nvm_mailbox;

  localparam int BUSY = 6;
  localparam logic [31:0] ST_OK = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nvm_mailbox #(.DATA_WORDS(16), .FLASH_WORDS(64), .BUSY_CYCLES(BUSY)) i_nvm_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] cnt,
                                     input logic [21:0] addr, input logic hdr);
    return {op, cnt, addr, hdr, 1'b1};
  endfunction

  task automatic poll(output int set_cnt, output logic [31:0] st);
    logic [31:0] v;
    set_cnt = 0;
    rd(17, v);
    while (v[0] && set_cnt < 1000) begin
      set_cnt++;
      rd(17, v);
    end
    rd(18, st);
  endtask

  task automatic run(input logic [31:0] cmd, output logic [31:0] st);
    int n;
    wr(17, cmd);
    poll(n, st);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1, v);  check("R1 data reg after reset", v, 32'h0);
    rd(16, v); check("R1 last data reg after reset", v, 32'h0);
    rd(17, v); check("R1 command after reset", v, 32'h0);
    rd(18, v); check("R1 status after reset", v, 32'h0);
    rd(0, v);  check("R1 offset 0 reads 0", v, 32'h0);
    rd(31, v); check("R1 offset 31 reads 0", v, 32'h0);
  endtask

  task automatic t_block;
    logic [31:0] v, st;
    int n;
    for (int i = 0; i < 4; i++) wr(1 + i, 32'h1111_0000 + 32'(i));
    wr(17, mk(4'h0, 4'd3, 22'd8, 1'b0));
    poll(n, st);
    check("R4 block write status", st, ST_OK);
    checks++;
    if (n < BUSY) begin
      errors++;
      $display("FAIL R5 busy polls actual=%0d expected>=%0d", n, BUSY);
    end
    rd(17, v); check("R5 command after completion", v, mk(4'h0, 4'd3, 22'd8, 1'b0) & ~32'h1);
    for (int i = 0; i < 4; i++) wr(1 + i, 32'h0);
    run(mk(4'h2, 4'd4, 22'd8, 1'b0), st);
    check("R4 block read status", st, 32'h2000_0020);
    for (int i = 0; i < 4; i++) begin
      rd(1 + i, v); check("R2 R3 read back word", v, 32'h1111_0000 + 32'(i));
    end
  endtask

  task automatic t_full;
    logic [31:0] v, st;
    for (int i = 0; i < 16; i++) wr(1 + i, 32'h2200_0000 + 32'(i * 3));
    run(mk(4'h0, 4'd15, 22'd16, 1'b0), st);
    check("R2 sixteen-word write status", st, ST_OK);
    for (int i = 0; i < 16; i++) wr(1 + i, 32'hFFFF_FFFF);
    run(mk(4'h2, 4'd0, 22'd16, 1'b0), st);
    check("R3 count 0 read status", st, 32'h2000_0020);
    for (int i = 0; i < 16; i++) begin
      rd(1 + i, v); check("R3 count 0 reads sixteen", v, 32'h2200_0000 + 32'(i * 3));
    end
  endtask

  task automatic t_range;
    logic [31:0] v, st;
    run(mk(4'h2, 4'd8, 22'd60, 1'b0), st);
    check("R7 read past end status", st, 32'h2000_0022);
    rd(1, v); check("R7 window untouched by refused read", v, 32'h2200_0000);
    for (int i = 0; i < 4; i++) wr(1 + i, 32'hC0C0_0000 + 32'(i));
    run(mk(4'h0, 4'd3, 22'd60, 1'b0), st);
    check("R7 write ending at last word", st, ST_OK);
    for (int i = 0; i < 4; i++) wr(1 + i, 32'hBAD0_0000 + 32'(i));
    run(mk(4'h0, 4'd3, 22'd62, 1'b0), st);
    check("R7 write past end status", st, 32'h2000_0002);
    run(mk(4'h2, 4'd4, 22'd60, 1'b0), st);
    for (int i = 0; i < 4; i++) begin
      rd(1 + i, v); check("R7 flash untouched by refused write", v, 32'hC0C0_0000 + 32'(i));
    end
  endtask

  task automatic t_busy;
    logic [31:0] v, st;
    int n;
    wr(2, 32'h5555_0002);
    wr(17, mk(4'h2, 4'd1, 22'd8, 1'b0));
    wr(2, 32'hDEAD_BEEF);
    wr(17, mk(4'h4, 4'd0, 22'd0, 1'b0));
    poll(n, st);
    check("R6 command write while busy ignored", st, 32'h2000_0020);
    rd(1, v); check("R3 single word read", v, 32'h1111_0000);
    rd(2, v); check("R6 data write while busy ignored", v, 32'h5555_0002);
    wr(18, 32'hFFFF_FFFF);
    rd(18, v); check("R6 status write ignored", v, 32'h2000_0020);
    wr(17, 32'h4000_0000);
    repeat (BUSY + 4) @(negedge clk);
    rd(17, v); check("R5 cleared request stores only", v, 32'h4000_0000);
    rd(18, v); check("R5 no start without request", v, 32'h2000_0020);
  endtask

  task automatic t_header;
    logic [31:0] v, st;
    run(mk(4'h0, 4'd15, 22'h3fffff, 1'b1), st);
    check("R8 header write status", st, ST_OK);
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), st);
    check("R9 authenticate after header", st, 32'h2000_0010);
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), st);
    check("R9 authenticate without header", st, 32'h2000_0011);
    wr(1, 32'h7777_7777);
    run(mk(4'h0, 4'd0, 22'd8, 1'b1), st);
    check("R8 header flag at normal address", st, 32'h2000_0002);
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), st);
    check("R9 refused header not pending", st, 32'h2000_0011);
    run(mk(4'h2, 4'd1, 22'd8, 1'b0), st);
    rd(1, v); check("R8 refused header left flash", v, 32'h1111_0000);
    run(mk(4'h0, 4'd0, 22'h3fffff, 1'b0), st);
    check("R8 reserved address reroutes", st, ST_OK);
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), st);
    check("R9 authenticate after rerouted header", st, 32'h2000_0010);
  endtask

  task automatic t_power;
    logic [31:0] st;
    run(mk(4'h0, 4'd3, 22'h3fffff, 1'b1), st);
    run(mk(4'h4, 4'd0, 22'd0, 1'b0), st);
    check("R10 power cycle status", st, 32'h2000_0040);
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), st);
    check("R10 power cycle drops header", st, 32'h2000_0011);
  endtask

  task automatic t_badop;
    logic [31:0] v, st;
    run(mk(4'h7, 4'd2, 22'd8, 1'b0), st);
    check("R11 opcode 7", st, 32'h2000_0073);
    wr(1, 32'h3333_0001);
    run(mk(4'h3, 4'd1, 22'd8, 1'b0), st);
    check("R11 opcode 3", st, 32'h2000_0033);
    rd(1, v); check("R11 no data moved", v, 32'h3333_0001);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_block;
    t_full;
    t_range;
    t_busy;
    t_header;
    t_power;
    t_badop;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule